// File: doc/BRIEF.md
# Parallel Flash Read Responder

This block is the read side of a parallel NOR-style flash device that uses the classic unlock-and-command protocol. A command sequencer, which is a separate block, tells it which command mode is active. The block answers each read strobe with one 32-bit word. Depending on the mode, that word is array data, a device identification word, a byte of the common flash query table, or the device status byte.

The byte array is held inside the block. The sequencer fills it through a byte load port. In the busy mode every status read inverts status bit 6, and a strobe marks each status read. The block also keeps a direct-read flag. The sequencer clears the flag when command traffic starts. The block sets it again on its own after a run of plain reads while no command cycle is open.

Top module: `flash_read_responder`

## Requirements
- R1: A read presented with `rd_en` appears on `rd_data`, with `rd_valid` high, one clock later. `rd_valid` is low in every other cycle. After reset `rd_valid`=0, `status_rd`=0, `rd_data`=0 and `direct_rd`=1.
- R2: In mode 0 (array) and mode 1 (erase setup) a read returns the array bytes that start at `rd_addr`. `rd_size` selects the width: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. Unused upper bits are 0. Addresses wrap at the array size.
- R3: For multi-byte reads, `big_endian`=1 places the byte at the lowest address in the most significant position. `big_endian`=0 places it in the least significant position.
- R4: The query index is `rd_addr[7:0]` shifted right by 0, 1 or 2 for a device width of 1, 2 or 4 bytes. In mode 2 (identify), index 0 returns ID0, index 1 returns ID1 and index 2 returns 0. Each is zero-extended.
- R5: In mode 2, index 0x0E returns ID2 and index 0x0F returns ID3, unless the low byte of that word is 0xFF. In that case, and for any other index, the read returns array data as in R2.
- R6: In mode 3 (busy), a read returns the status byte zero-extended and pulses `status_rd` together with `rd_valid`. Bit 6 of the stored status is inverted after each such read. `st_load` replaces the status with `st_value`.
- R7: In mode 4 (query), indices 0x00 to 0x51 return the table byte. Any higher index returns 0.
- R8: Query table contents:
  - 0x10 to 0x12 hold 0x51, 0x52, 0x59.
  - 0x13 holds 0x02, 0x14 holds 0x00, 0x15 holds 0x31.
  - 0x27 holds ADDR_W.
  - 0x2C holds 0x01.
  - 0x2D to 0x2E hold sector count minus 1, and 0x2F to 0x30 hold sector length / 256, each little-endian.
- R9: `io_enter` clears `direct_rd` and the read count. While `direct_rd` is 0, each read with `cmd_idle`=1 is counted. The 43rd counted read sets `direct_rd`, visible with its data. Reads with `cmd_idle`=0 are not counted.
- R10: Modes 5 to 7 return array data as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Byte address |
| rd_size | input | 2 | Access size code |
| big_endian | input | 1 | Byte order of multi-byte reads |
| cmd_mode | input | 3 | Command mode from the sequencer |
| cmd_idle | input | 1 | No command cycle is open |
| io_enter | input | 1 | Leave direct-read mode |
| st_load | input | 1 | Load status byte |
| st_value | input | 8 | Status byte to load |
| ld_en | input | 1 | Array byte load strobe |
| ld_addr | input | ADDR_W | Array load address |
| ld_data | input | 8 | Array load byte |
| rd_data | output | 32 | Registered read word |
| rd_valid | output | 1 | Read word valid |
| status_rd | output | 1 | A status read happened |
| direct_rd | output | 1 | Direct-read mode flag |

## Verification
The bench probes the identify fallbacks: ID3 has a low byte of 0xFF, and index 0x20 lies outside the identify slots. A design that skipped either fallback would return an ID word or zero where array bytes are expected. Query reads at 0x51, 0x52 and above catch an off-by-one at the table edge, which would show up as a nonzero byte. Back-to-back status reads show whether bit 6 really alternates. The lazy counter is driven to exactly 42 and then 43 counted reads, with uncounted busy-cycle reads in between, so an early or late return to direct mode is caught. Multi-byte reads at the top address check both byte orders and the wrap at the array edge.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;
  typedef enum logic [2:0] {
    MODE_ARRAY  = 3'd0,
    MODE_ESETUP = 3'd1,
    MODE_IDENT  = 3'd2,
    MODE_BUSY   = 3'd3,
    MODE_QUERY  = 3'd4
  } rd_mode_e;

  localparam logic [7:0] QUERY_LAST = 8'h51;
  localparam logic [7:0] STATUS_TOGGLE = 8'h40;
endpackage

// File: rtl/flash_byte_array.sv
module flash_byte_array #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [7:0]        ld_data,
  input  logic [ADDR_W-1:0] base,
  output logic [31:0]       lanes
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (ld_en) begin
      mem[ld_addr] <= ld_data;
    end
  end

  // lane k holds the byte at base + k, wrapping at the array size
  for (genvar k = 0; k < 4; k++) begin : g_lane
    logic [ADDR_W-1:0] a_k;
    assign a_k = base + ADDR_W'(k);
    assign lanes[8*k +: 8] = mem[a_k];
  end
endmodule

// File: rtl/flash_query_rom.sv
module flash_query_rom #(
  parameter int ADDR_W   = 10,
  parameter int SECTOR_W = 8
) (
  input  logic [7:0] idx,
  output logic [7:0] qbyte
);
  localparam logic [15:0] NSEC_M1 = 16'((1 << (ADDR_W - SECTOR_W)) - 1);
  localparam logic [31:0] SEC_LEN = 32'(1) << SECTOR_W;

  always_comb begin
    case (idx)
      8'h10: qbyte = 8'h51;
      8'h11: qbyte = 8'h52;
      8'h12: qbyte = 8'h59;
      8'h13: qbyte = 8'h02;
      8'h15: qbyte = 8'h31;
      8'h1B: qbyte = 8'h27;
      8'h1C: qbyte = 8'h36;
      8'h1F: qbyte = 8'h07;
      8'h21: qbyte = 8'h09;
      8'h22: qbyte = 8'h0C;
      8'h23: qbyte = 8'h01;
      8'h25: qbyte = 8'h0A;
      8'h26: qbyte = 8'h0D;
      8'h27: qbyte = 8'(ADDR_W);
      8'h28: qbyte = 8'h02;
      8'h2C: qbyte = 8'h01;
      8'h2D: qbyte = NSEC_M1[7:0];
      8'h2E: qbyte = NSEC_M1[15:8];
      8'h2F: qbyte = SEC_LEN[15:8];
      8'h30: qbyte = SEC_LEN[23:16];
      8'h31: qbyte = 8'h50;
      8'h32: qbyte = 8'h52;
      8'h33: qbyte = 8'h49;
      8'h34: qbyte = 8'h31;
      8'h35: qbyte = 8'h30;
      default: qbyte = 8'h00;
    endcase
  end
endmodule

// File: rtl/flash_lazy_mode.sv
module flash_lazy_mode #(
  parameter int LIMIT = 42
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_en,
  input  logic cmd_idle,
  input  logic io_enter,
  output logic direct_rd
);
  localparam int CW = $clog2(LIMIT + 2);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          dir_q, dir_n;

  always_comb begin
    cnt_n = cnt_q;
    dir_n = dir_q;
    if (io_enter) begin
      cnt_n = '0;
      dir_n = 1'b0;
    end else if (rd_en && !dir_q && cmd_idle) begin
      cnt_n = cnt_q + 1'b1;
      if (cnt_n > CW'(LIMIT)) begin
        dir_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
    end else begin
      cnt_q <= cnt_n;
      dir_q <= dir_n;
    end
  end

  assign direct_rd = dir_q;
endmodule

// File: rtl/flash_read_responder.sv
module flash_read_responder
  import flash_rd_pkg::*;
#(
  parameter int          ADDR_W    = 10,
  parameter int          SECTOR_W  = 8,
  parameter int          DEV_WIDTH = 1,
  parameter int          LAZY_LIMIT = 42,
  parameter logic [15:0] ID0 = 16'h0001,
  parameter logic [15:0] ID1 = 16'h227E,
  parameter logic [15:0] ID2 = 16'h2213,
  parameter logic [15:0] ID3 = 16'h00FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [1:0]        rd_size,
  input  logic              big_endian,
  input  logic [2:0]        cmd_mode,
  input  logic              cmd_idle,
  input  logic              io_enter,
  input  logic              st_load,
  input  logic [7:0]        st_value,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [7:0]        ld_data,
  output logic [31:0]       rd_data,
  output logic              rd_valid,
  output logic              status_rd,
  output logic              direct_rd
);
  localparam int SHIFT = (DEV_WIDTH == 4) ? 2 : (DEV_WIDTH == 2) ? 1 : 0;

  logic [31:0] lanes;
  logic [31:0] arr_word;
  logic [7:0]  q_idx;
  logic [7:0]  q_byte;
  logic [7:0]  st_q, st_n;
  logic [31:0] word_n;
  logic        busy_rd;
  logic [31:0] data_q;
  logic        valid_q, strobe_q;

  flash_byte_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .base(rd_addr), .lanes(lanes)
  );

  flash_query_rom #(.ADDR_W(ADDR_W), .SECTOR_W(SECTOR_W)) u_query (
    .idx(q_idx), .qbyte(q_byte)
  );

  flash_lazy_mode #(.LIMIT(LAZY_LIMIT)) u_lazy (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .cmd_idle(cmd_idle),
    .io_enter(io_enter), .direct_rd(direct_rd)
  );

  assign q_idx   = rd_addr[7:0] >> SHIFT;
  assign busy_rd = rd_en && (cmd_mode == MODE_BUSY);

  // byte assembly for array reads
  always_comb begin
    case (rd_size)
      2'd0:    arr_word = {24'h0, lanes[7:0]};
      2'd1:    arr_word = big_endian ? {16'h0, lanes[7:0], lanes[15:8]}
                                     : {16'h0, lanes[15:0]};
      default: arr_word = big_endian ? {lanes[7:0], lanes[15:8], lanes[23:16], lanes[31:24]}
                                     : lanes;
    endcase
  end

  // mode-dependent response selection
  always_comb begin
    word_n = arr_word;
    case (cmd_mode)
      MODE_IDENT: begin
        case (q_idx)
          8'h00: word_n = {16'h0, ID0};
          8'h01: word_n = {16'h0, ID1};
          8'h02: word_n = 32'h0;
          8'h0E: if (ID2[7:0] != 8'hFF) word_n = {16'h0, ID2};
          8'h0F: if (ID3[7:0] != 8'hFF) word_n = {16'h0, ID3};
          default: word_n = arr_word;
        endcase
      end
      MODE_BUSY:  word_n = {24'h0, st_q};
      MODE_QUERY: word_n = {24'h0, (q_idx > QUERY_LAST) ? 8'h00 : q_byte};
      default:    word_n = arr_word;
    endcase
  end

  always_comb begin
    st_n = st_q;
    if (st_load) begin
      st_n = st_value;
    end else if (busy_rd) begin
      st_n = st_q ^ STATUS_TOGGLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= 8'h00;
      data_q   <= 32'h0;
      valid_q  <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      st_q     <= st_n;
      valid_q  <= rd_en;
      strobe_q <= busy_rd;
      if (rd_en) begin
        data_q <= word_n;
      end
    end
  end

  assign rd_data   = data_q;
  assign rd_valid  = valid_q;
  assign status_rd = strobe_q;
endmodule

// File: rtl/flash_rd_checker.sv
module flash_rd_checker
  import flash_rd_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DEV_WIDTH = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [1:0]        rd_size,
  input logic [2:0]        cmd_mode,
  input logic              io_enter,
  input logic              st_load,
  input logic [31:0]       rd_data,
  input logic              rd_valid,
  input logic              status_rd,
  input logic              direct_rd
);
  localparam int SHIFT = (DEV_WIDTH == 4) ? 2 : (DEV_WIDTH == 2) ? 1 : 0;
  logic [7:0] c_idx;
  assign c_idx = rd_addr[7:0] >> SHIFT;

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid) else $error("valid latency"); // R1
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid) else $error("spurious valid"); // R1
  AST_BYTE_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_size == 2'd0 && cmd_mode == MODE_ARRAY) |=> (rd_data[31:8] == 24'h0))
    else $error("byte read upper bits"); // R2
  AST_STATUS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd |-> rd_valid) else $error("strobe without valid"); // R6
  AST_STATUS_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && $past(status_rd) && !$past(st_load, 2)) |->
      ((rd_data[7:0] ^ $past(rd_data[7:0])) == STATUS_TOGGLE))
    else $error("status toggle"); // R6
  AST_QUERY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && cmd_mode == MODE_QUERY && c_idx > QUERY_LAST) |=> (rd_data == 32'h0))
    else $error("query out of range"); // R7
  AST_DIRECT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    io_enter |=> !direct_rd) else $error("direct not cleared"); // R9
  AST_DIRECT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(direct_rd) |-> $past(rd_en)) else $error("direct rose without read"); // R9
endmodule

bind flash_read_responder flash_rd_checker #(.ADDR_W(ADDR_W), .DEV_WIDTH(DEV_WIDTH)) u_chk (.*);

// File: tb/sim_flash_read_responder.sv
module sim_flash_read_responder;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [1:0]    rd_size = '0;
  logic          big_endian = 1'b0;
  logic [2:0]    cmd_mode = '0;
  logic          cmd_idle = 1'b1;
  logic          io_enter = 1'b0;
  logic          st_load = 1'b0;
  logic [7:0]    st_value = '0;
  logic          ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [7:0]    ld_data = '0;
  logic [31:0]   rd_data;
  logic          rd_valid, status_rd, direct_rd;

  int checks = 0;
  int errors = 0;
  logic [7:0] mem_m [DEPTH];
  logic [7:0] st_m = 8'h00;
  logic       dir_m = 1'b1;
  int         cnt_m = 0;

  always #4 clk = ~clk;

  flash_read_responder u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] arr_exp(input logic [AW-1:0] a, input logic [1:0] sz, input logic be);
    logic [7:0] b [4];
    for (int k = 0; k < 4; k++) b[k] = mem_m[AW'(a + AW'(k))];
    if (sz == 2'd0) return {24'h0, b[0]};
    if (sz == 2'd1) return be ? {16'h0, b[0], b[1]} : {16'h0, b[1], b[0]};
    return be ? {b[0], b[1], b[2], b[3]} : {b[3], b[2], b[1], b[0]};
  endfunction

  function automatic logic [7:0] query_exp(input logic [7:0] i);
    case (i)
      8'h10: return 8'h51; 8'h11: return 8'h52; 8'h12: return 8'h59;
      8'h13: return 8'h02; 8'h15: return 8'h31; 8'h1B: return 8'h27;
      8'h1C: return 8'h36; 8'h1F: return 8'h07; 8'h21: return 8'h09;
      8'h22: return 8'h0C; 8'h23: return 8'h01; 8'h25: return 8'h0A;
      8'h26: return 8'h0D; 8'h27: return 8'd10; 8'h28: return 8'h02;
      8'h2C: return 8'h01; 8'h2D: return 8'h03; 8'h2F: return 8'h01;
      8'h31: return 8'h50; 8'h32: return 8'h52; 8'h33: return 8'h49;
      8'h34: return 8'h31; 8'h35: return 8'h30;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [31:0] word_exp(input logic [AW-1:0] a, input logic [1:0] sz,
                                           input logic be, input logic [2:0] m);
    logic [7:0] i;
    i = a[7:0];
    case (m)
      3'd2: begin
        if (i == 8'h00) return 32'h0001;
        if (i == 8'h01) return 32'h227E;
        if (i == 8'h02) return 32'h0;
        if (i == 8'h0E) return 32'h2213;
        return arr_exp(a, sz, be);
      end
      3'd3: return {24'h0, st_m};
      3'd4: return {24'h0, query_exp(i)};
      default: return arr_exp(a, sz, be);
    endcase
  endfunction

  task automatic do_read(input string req, input logic [AW-1:0] a, input logic [1:0] sz,
                         input logic be, input logic [2:0] m, input logic idle);
    logic [31:0] e;
    logic        e_st;
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a; rd_size = sz; big_endian = be; cmd_mode = m; cmd_idle = idle;
    e = word_exp(a, sz, be, m);
    e_st = (m == 3'd3);
    if (e_st) st_m = st_m ^ 8'h40;
    if (!dir_m && idle) begin
      cnt_m++;
      if (cnt_m > 42) dir_m = 1'b1;
    end
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, rd_data, e);
    chk({req, " valid"}, {31'h0, rd_valid}, 32'h1);
    chk("R6 strobe", {31'h0, status_rd}, {31'h0, e_st});
    chk("R9 direct", {31'h0, direct_rd}, {31'h0, dir_m});
  endtask

  task automatic enter_io();
    @(negedge clk); io_enter = 1'b1;
    @(negedge clk); io_enter = 1'b0;
    dir_m = 1'b0; cnt_m = 0;
  endtask

  task automatic load_status(input logic [7:0] v);
    @(negedge clk); st_load = 1'b1; st_value = v;
    @(negedge clk); st_load = 1'b0;
    st_m = v;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {31'h0, rd_valid}, 32'h0);
    chk("R1 reset strobe", {31'h0, status_rd}, 32'h0);
    chk("R1 reset data", rd_data, 32'h0);
    chk("R1 reset direct", {31'h0, direct_rd}, 32'h1);
    rst_n = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = AW'(i); ld_data = 8'($urandom);
      mem_m[i] = ld_data;
    end
    @(negedge clk); ld_en = 1'b0;
    // R1 idle cycle keeps valid low
    @(negedge clk);
    chk("R1 idle valid", {31'h0, rd_valid}, 32'h0);
    // R2 R3 array, wrap at top
    do_read("R2 byte", 10'h005, 2'd0, 1'b0, 3'd0, 1'b1);
    do_read("R3 half le", 10'h100, 2'd1, 1'b0, 3'd0, 1'b1);
    do_read("R3 half be", 10'h100, 2'd1, 1'b1, 3'd0, 1'b1);
    do_read("R3 word be wrap", 10'h3FE, 2'd2, 1'b1, 3'd0, 1'b1);
    do_read("R2 word le wrap", 10'h3FF, 2'd3, 1'b0, 3'd1, 1'b1);
    do_read("R10 mode7", 10'h044, 2'd2, 1'b0, 3'd7, 1'b1);
    // R4 R5 identify
    do_read("R4 id0", 10'h000, 2'd1, 1'b0, 3'd2, 1'b1);
    do_read("R4 id1", 10'h001, 2'd1, 1'b0, 3'd2, 1'b1);
    do_read("R4 prot", 10'h002, 2'd1, 1'b0, 3'd2, 1'b1);
    do_read("R5 id2", 10'h00E, 2'd1, 1'b0, 3'd2, 1'b1);
    do_read("R5 id3 fallback", 10'h00F, 2'd1, 1'b1, 3'd2, 1'b1);
    do_read("R5 other idx", 10'h120, 2'd2, 1'b0, 3'd2, 1'b1);
    // R7 R8 query table
    do_read("R8 Q", 10'h010, 2'd0, 1'b0, 3'd4, 1'b1);
    do_read("R8 R", 10'h011, 2'd0, 1'b0, 3'd4, 1'b1);
    do_read("R8 Y", 10'h012, 2'd0, 1'b0, 3'd4, 1'b1);
    do_read("R8 cmdset", 10'h013, 2'd0, 1'b0, 3'd4, 1'b1);
    do_read("R8 ext", 10'h015, 2'd0, 1'b0, 3'd4, 1'b1);
    do_read("R8 size", 10'h027, 2'd0, 1'b0, 3'd4, 1'b1);
    do_read("R8 regions", 10'h02C, 2'd0, 1'b0, 3'd4, 1'b1);
    do_read("R8 nsec", 10'h02D, 2'd0, 1'b0, 3'd4, 1'b1);
    do_read("R8 seclen", 10'h02F, 2'd0, 1'b0, 3'd4, 1'b1);
    do_read("R7 last", 10'h051, 2'd0, 1'b0, 3'd4, 1'b1);
    do_read("R7 over", 10'h052, 2'd0, 1'b0, 3'd4, 1'b1);
    do_read("R7 far", 10'h2F0, 2'd0, 1'b0, 3'd4, 1'b1);
    // R6 status
    load_status(8'h80);
    do_read("R6 st a", 10'h000, 2'd0, 1'b0, 3'd3, 1'b0);
    do_read("R6 st b", 10'h000, 2'd0, 1'b0, 3'd3, 1'b0);
    do_read("R6 st c", 10'h000, 2'd0, 1'b0, 3'd3, 1'b0);
    // R9 lazy return
    enter_io();
    chk("R9 cleared", {31'h0, direct_rd}, 32'h0);
    for (int i = 0; i < 42; i++) do_read("R9 count", AW'(i), 2'd0, 1'b0, 3'd0, 1'b1);
    do_read("R9 busy not counted", 10'h0, 2'd0, 1'b0, 3'd0, 1'b0);
    do_read("R9 43rd", 10'h0, 2'd0, 1'b0, 3'd0, 1'b1);
    // random mix
    for (int n = 0; n < 600; n++) begin
      if ($urandom_range(0, 40) == 0) enter_io();
      if ($urandom_range(0, 30) == 0) load_status(8'($urandom));
      do_read("R2 random", AW'($urandom), 2'($urandom), 1'($urandom),
              3'($urandom_range(0, 7)), 1'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule